// File: doc/BRIEF.md
# Oversampled NRZ Serial Receiver with Holding Register

This block takes an asynchronous NRZ serial line and recovers characters from it. The line passes through a two-stage synchronizer. A receive-time tick, supplied from outside at sixteen times the bit rate, then paces a frame engine. The engine finds the leading edge of the start bit and decides every bit by a three-sample majority vote near the bit centre. It shifts the data bits, least significant first, into a private shift register.

A frame has either eight or nine data bits, selected by a mode input. The ninth bit is delivered on its own output, so software can use it as parity, as an address/control marker, or as a second stop bit. When the stop bit has been judged, the character moves at once into a parallel holding register and a ready flag is raised. The shift register is then free for the next frame while software has not yet read the previous character. A framing-error flag accompanies each transfer. Dropping the enable input holds the whole receive engine idle.

Top module: `nrz_rx_dbuf`

## Requirements
- R1: A frame is a start bit at 0, the data bits least significant first, then a stop bit at 1. The first data bit received appears on `rx_byte[0]` and the eighth on `rx_byte[7]`.
- R2: With `nine_bit`=1 a frame carries nine data bits, and the bit that follows the eighth appears on `rx_bit9`. With `nine_bit`=0, `rx_bit9` reads 0. The mode is captured when the start edge is detected, so changing it during a frame has no effect on that frame.
- R3: Only clock cycles with `os_tick`=1 advance the receiver, and each bit lasts 16 ticks.
- R4: Ticks within a bit are numbered 1 to 16, with tick 1 the start-detection tick. Each bit takes the majority of the synchronized line at ticks 8, 9 and 10. One flipped sample does not change the bit; two flipped samples do.
- R5: A start is detected on a tick where the synchronized line is 0 and it was 1 on the previous tick. If the start-bit majority is 1, the receiver returns to idle and transfers nothing.
- R6: At tick 10 of the stop bit the character is copied into the holding register. `rx_byte` and `rx_bit9` do not change at any other time, and a following frame is received while the previous character is still unread.
- R7: `rx_frame_err` is set to 1 with a transfer whose stop-bit majority is 0 and to 0 with a transfer whose stop bit is 1. The data is delivered in both cases.
- R8: `rx_ready` rises on every transfer. It falls in the cycle after `rd_ack`=1, unless a transfer happens in the same cycle, in which case it stays 1.
- R9: While `rx_en`=0 the synchronizer and frame engine are held idle and any frame in progress is abandoned. The holding register and flags keep their values.
- R10: After reset `rx_byte`, `rx_bit9`, `rx_ready` and `rx_frame_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; 0 holds the engine idle |
| os_tick | input | 1 | Oversample tick, 16 per bit time |
| nine_bit | input | 1 | 1 selects nine data bits per frame |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd_ack | input | 1 | Read acknowledge; clears `rx_ready` |
| rx_byte | output | 8 | Held data byte |
| rx_bit9 | output | 1 | Held ninth data bit |
| rx_ready | output | 1 | A character is waiting |
| rx_frame_err | output | 1 | Stop bit of the held character read as 0 |

## Verification
The receiver is exercised with several kinds of line pattern. Clean eight-bit and nine-bit frames show that bit order and the separate ninth bit are right. Back-to-back frames with no acknowledge show that the holding register stays stable while the next frame is shifted in. Single-sample and two-sample glitches at the bit centre separate a true majority vote from plain centre sampling. A short low pulse, a stop bit held at 0 and a mid-frame disable show the false-start, framing-error and abort paths. A slower tick rate and a mode change during a frame show that only ticks advance the engine and that the mode is captured at the start edge.

// File: rtl/nrz_rx_pkg.sv
package nrz_rx_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              bit9;
        logic              ready;
        logic              ferr;
    } hold_t;
endpackage

// File: rtl/nrz_rx_sync.sv
module nrz_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = en ? din : 1'b1;
        end else begin : g_many
            always_comb chain_d = en ? {chain_q[STAGES-2:0], din} : '1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nrz_rx_vote.sv
module nrz_rx_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic take,
    input  logic s,
    output logic maj
);
    logic [1:0] ones_d, ones_q;

    always_comb begin
        ones_d = ones_q;
        if (clr)            ones_d = 2'd0;
        else if (take && s) ones_d = ones_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ones_q <= 2'd0;
        else        ones_q <= ones_d;
    end

    // the current sample counts toward the decision made in the same tick
    assign maj = (ones_q == 2'd2) || (ones_q == 2'd1 && take && s) || (ones_q == 2'd3);
endmodule

// File: rtl/nrz_rx_frame.sv
module nrz_rx_frame #(
    parameter int OVS = 16,
    parameter int MID = 9,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          nine_sel,
    input  logic          rxs,
    input  logic          maj,
    output logic          take,
    output logic          clr,
    output logic          done,
    output logic [DW-1:0] done_byte,
    output logic          done_bit9,
    output logic          done_ferr
);
    localparam int SW = DW + 1;
    localparam int CW = $clog2(OVS + 1);
    localparam int IW = $clog2(DW + 3);
    localparam logic [CW-1:0] C_LAST  = CW'(OVS);
    localparam logic [CW-1:0] C_FIRST = CW'(MID - 1);
    localparam logic [CW-1:0] C_DEC   = CW'(MID + 1);
    localparam logic [IW-1:0] I_D8    = IW'(DW);
    localparam logic [IW-1:0] I_D9    = IW'(DW + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic          nine;
        logic          last;
        logic [SW-1:0] sh;
    } fr_t;

    fr_t           q, d;
    logic [CW-1:0] cur;
    logic [IW-1:0] last_data;

    assign cur       = q.cnt + CW'(1);
    assign last_data = q.nine ? I_D9 : I_D8;
    assign take      = en && tick && q.busy && (cur >= C_FIRST) && (cur <= C_DEC);
    assign clr       = !en || !q.busy || (tick && cur == C_LAST);

    always_comb begin
        d         = q;
        done      = 1'b0;
        done_ferr = 1'b0;
        if (!en) begin
            d.busy = 1'b0;
            d.cnt  = '0;
            d.idx  = '0;
            d.last = 1'b0;
        end else if (tick) begin
            d.last = rxs;
            if (!q.busy) begin
                if (!rxs && q.last) begin
                    d.busy = 1'b1;
                    d.cnt  = CW'(1);
                    d.idx  = '0;
                    d.nine = nine_sel;
                end
            end else begin
                d.cnt = cur;
                if (cur == C_DEC) begin
                    if (q.idx == '0) begin
                        if (maj) d.busy = 1'b0;       // false start
                    end else if (q.idx <= last_data) begin
                        d.sh = {maj, q.sh[SW-1:1]};
                    end else begin
                        done      = 1'b1;
                        done_ferr = !maj;
                        d.busy    = 1'b0;
                    end
                end
                if (cur == C_LAST) begin
                    d.cnt = '0;
                    d.idx = q.idx + IW'(1);
                end
            end
        end
    end

    assign done_byte = q.nine ? q.sh[DW-1:0] : q.sh[SW-1:1];
    assign done_bit9 = q.nine & q.sh[SW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !q.busy);
endmodule

// File: rtl/nrz_rx_dbuf.sv
module nrz_rx_dbuf
    import nrz_rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int MID       = 9,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              os_tick,
    input  logic              nine_bit,
    input  logic              rxd,
    input  logic              rd_ack,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_ready,
    output logic              rx_frame_err
);
    logic              rxs, maj, take, clr, done, d_bit9, d_ferr;
    logic [BYTE_W-1:0] d_byte;
    hold_t             h_d, h_q;

    nrz_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .din(rxd), .dout(rxs));

    nrz_rx_vote u_vote (
        .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .s(rxs), .maj(maj));

    nrz_rx_frame #(.OVS(OVS), .MID(MID), .DW(BYTE_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .nine_sel(nine_bit),
        .rxs(rxs), .maj(maj), .take(take), .clr(clr), .done(done),
        .done_byte(d_byte), .done_bit9(d_bit9), .done_ferr(d_ferr));

    always_comb begin
        h_d = h_q;
        if (rd_ack) h_d.ready = 1'b0;
        if (done) begin
            h_d.data  = d_byte;
            h_d.bit9  = d_bit9;
            h_d.ready = 1'b1;
            h_d.ferr  = d_ferr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign rx_byte      = h_q.data;
    assign rx_bit9      = h_q.bit9;
    assign rx_ready     = h_q.ready;
    assign rx_frame_err = h_q.ferr;

    // R8
    ready_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_ready);
    // R8
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !done) |=> !rx_ready);
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(rx_byte) && $stable(rx_bit9)));
    // R7
    ferr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rx_frame_err == $past(d_ferr)));
endmodule

// File: tb/tb_nrz_rx_dbuf.sv
module tb_nrz_rx_dbuf;
    logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b1, os_tick = 1'b0;
    logic nine_bit = 1'b0, rxd = 1'b1, rd_ack = 1'b0;
    logic [7:0] rx_byte;
    logic rx_bit9, rx_ready, rx_frame_err;
    int checks = 0, failures = 0, tdiv = 1, dcnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nrz_rx_dbuf dut (.clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick),
        .nine_bit(nine_bit), .rxd(rxd), .rd_ack(rd_ack), .rx_byte(rx_byte),
        .rx_bit9(rx_bit9), .rx_ready(rx_ready), .rx_frame_err(rx_frame_err));

    // tick generator, driven away from the active edge
    always @(negedge clk) begin
        dcnt    = (dcnt + 1 >= tdiv) ? 0 : dcnt + 1;
        os_tick = (dcnt == 0);
    end

    // behavioural reference model
    int m_s1 = 1, m_s2 = 1, m_last = 0, m_busy = 0, m_cnt = 0, m_idx = 0, m_ones = 0, m_nine = 0;
    int m_data = 0, m_byte = 0, m_b9 = 0, m_rdy = 0, m_fe = 0;
    always @(posedge clk) begin
        int s, cur, nd;
        bit mj;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_last = 0; m_busy = 0; m_cnt = 0; m_idx = 0; m_ones = 0;
            m_byte = 0; m_b9 = 0; m_rdy = 0; m_fe = 0;
        end else begin
            s = m_s2;
            if (rd_ack) m_rdy = 0;
            if (!rx_en) begin
                m_busy = 0; m_cnt = 0; m_idx = 0; m_last = 0; m_ones = 0;
            end else if (os_tick) begin
                if (m_busy == 0) begin
                    m_ones = 0;
                    if (s == 0 && m_last == 1) begin
                        m_busy = 1; m_cnt = 1; m_idx = 0; m_nine = nine_bit; m_data = 0;
                    end
                end else begin
                    cur = m_cnt + 1;
                    m_cnt = cur;
                    if (cur >= 8 && cur <= 10) m_ones += s;
                    if (cur == 10) begin
                        mj = (m_ones >= 2);
                        nd = m_nine ? 9 : 8;
                        if (m_idx == 0) begin
                            if (mj) m_busy = 0;
                        end else if (m_idx <= nd) begin
                            if (mj) m_data |= (1 << (m_idx - 1));
                        end else begin
                            m_byte = m_data & 8'hFF;
                            m_b9 = m_nine ? ((m_data >> 8) & 1) : 0;
                            m_rdy = 1; m_fe = mj ? 0 : 1; m_busy = 0;
                        end
                    end
                    if (cur == 16) begin m_cnt = 0; m_idx++; m_ones = 0; end
                end
                m_last = s;
            end else if (m_busy == 0) m_ones = 0;
            if (!rx_en) begin m_s1 = 1; m_s2 = 1; end
            else begin m_s2 = m_s1; m_s1 = rxd; end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) if (rst_n && !finished) begin
        chk("R6 byte", rx_byte, m_byte);
        chk("R2 bit9", rx_bit9, m_b9);
        chk("R8 ready", rx_ready, m_rdy);
        chk("R7 ferr", rx_frame_err, m_fe);
    end

    task automatic hold(input logic v, input int nticks);
        @(negedge clk); rxd = v;
        repeat (nticks * tdiv - 1) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input bit nine, input logic stopv,
                        input int gb, input logic [15:0] gm);
        int nb = nine ? 9 : 8;
        for (int b = 0; b < nb + 2; b++) begin
            logic lv = (b == 0) ? 1'b0 : (b <= nb) ? d[b-1] : stopv;
            for (int k = 0; k < 16; k++)
                hold(lv ^ ((b == gb) && gm[k]), 1);
        end
        hold(1'b1, 40);
    endtask

    task automatic ack();
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
    endtask

    task automatic report();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10 reset state
        chk("R10 byte", rx_byte, 0); chk("R10 ready", rx_ready, 0);
        chk("R10 bit9", rx_bit9, 0); chk("R10 ferr", rx_frame_err, 0);
        rst_n = 1'b1;
        hold(1'b1, 20);
        // R1 basic eight-bit frame
        send(9'h0A5, 0, 1'b1, -1, 16'h0);
        chk("R1 byte", rx_byte, 8'hA5); chk("R8 ready set", rx_ready, 1);
        chk("R7 ferr clear", rx_frame_err, 0); chk("R2 bit9 zero", rx_bit9, 0);
        ack(); chk("R8 ready cleared", rx_ready, 0);
        // R2 nine-bit frame
        nine_bit = 1'b1;
        send(9'h13C, 1, 1'b1, -1, 16'h0);
        chk("R2 byte", rx_byte, 8'h3C); chk("R2 bit9", rx_bit9, 1);
        ack();
        // R2 mode captured at start edge
        nine_bit = 1'b0;
        fork
            send(9'h081, 0, 1'b1, -1, 16'h0);
            begin repeat (40) @(negedge clk); nine_bit = 1'b1; end
        join
        chk("R2 mode latched byte", rx_byte, 8'h81); chk("R2 mode latched bit9", rx_bit9, 0);
        nine_bit = 1'b0;
        ack();
        // R6 double buffering: second frame arrives while first unread
        send(9'h011, 0, 1'b1, -1, 16'h0);
        fork
            send(9'h022, 0, 1'b1, -1, 16'h0);
            begin
                repeat (80) @(negedge clk);
                chk("R6 held during next frame", rx_byte, 8'h11);
                chk("R6 ready held", rx_ready, 1);
            end
        join
        chk("R6 second byte", rx_byte, 8'h22);
        ack();
        // R7 framing error, data still delivered
        send(9'h05A, 0, 1'b0, -1, 16'h0);
        chk("R7 byte kept", rx_byte, 8'h5A); chk("R7 ferr set", rx_frame_err, 1);
        send(9'h066, 0, 1'b1, -1, 16'h0);
        chk("R7 ferr cleared", rx_frame_err, 0);
        ack();
        // R4 majority vote: single flip ignored, double flip wins
        send(9'h000, 0, 1'b1, 2, 16'h0100);
        chk("R4 single flip", rx_byte, 8'h00);
        send(9'h000, 0, 1'b1, 2, 16'h0180);
        chk("R4 double flip", rx_byte, 8'h02);
        ack();
        // R5 false start
        hold(1'b0, 4); hold(1'b1, 60);
        chk("R5 no transfer", rx_ready, 0); chk("R5 byte kept", rx_byte, 8'h02);
        send(9'h03C, 0, 1'b1, -1, 16'h0);
        chk("R5 recovers", rx_byte, 8'h3C);
        ack();
        // R9 disable mid-frame
        hold(1'b0, 16); hold(1'b1, 24);
        @(negedge clk); rx_en = 1'b0;
        repeat (5) @(negedge clk); rx_en = 1'b1;
        hold(1'b1, 200);
        chk("R9 abandoned", rx_ready, 0); chk("R9 byte kept", rx_byte, 8'h3C);
        send(9'h0E7, 0, 1'b1, -1, 16'h0);
        chk("R9 after reenable", rx_byte, 8'hE7);
        ack();
        // R3 slower tick rate
        tdiv = 3;
        hold(1'b1, 10);
        send(9'h0C3, 0, 1'b1, -1, 16'h0);
        chk("R3 slow ticks byte", rx_byte, 8'hC3); chk("R3 slow ticks ready", rx_ready, 1);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule